// File: doc/BRIEF.md
# Vectored Nesting Interrupt Collector

This block gathers 128 level-sensitive interrupt request lines. Each line has an enable bit and a two-bit priority level. From the enabled, pending lines it picks one winner: the highest level takes precedence, and within a level the lowest line number wins. When the winner outranks every level that is already in service, the block raises an interrupt toward the CPU. At that moment it latches a vector address equal to a programmable base plus the winner number times a selectable spacing.

The CPU reads the vector, runs the handler and marks the level as in service, either by writing the vector register or, in the optional mode, by reading it. The handler ends with a write of its level to the acknowledge register. Higher levels can preempt lower ones unless nesting is switched off.

Control fields add several behaviours:
- A self-clearing-style soft reset holds the collector in reset and sets the clock-gate bit by itself four clocks later.
- The clock-gate bit freezes all state except the control register.
- A test bypass mode makes the vector follow the current winner every cycle, with no CPU handshake.

Top module: `irq_vec_collector`

## Requirements
- R1: The winner is the enabled pending request with the highest level (3 highest, 0 lowest); among equal levels the lowest request number wins; a disabled request never wins.
- R2: The vector equals base + winner × spacing. The spacing is set by control bits 6:4: codes 0 and 1 give 4 bytes, and code k (2 to 7) gives 4·k bytes. With no winner in bypass mode, the vector equals base.
- R3: Out of reset, irq_o is low and every register reads zero. When idle, a qualifying winner raises irq_o after one clock edge, and the captured vector is then held.
- R4: With control bit 10 clear, a write to the vector register (offset 2) marks the captured level in service and drops irq_o after that edge; a read has no side effect.
- R5: With control bit 10 set, a read of the vector register marks the captured level in service and drops irq_o.
- R6: A winner raises irq_o only if its level is strictly above every in-service level. A higher level preempts a lower one in service; an equal level does not.
- R7: With control bit 9 set (nesting off), irq_o does not rise while any level is in service.
- R8: Writing a level number to the acknowledge register (offset 4, bits 1:0) clears that level's in-service flag. Reads of offset 4 return the in-service flags, one bit per level.
- R9: Setting control bit 0 (soft reset) clears base, per-request configuration, in-service flags and the vector, and sets control bit 1 (clock gate) at the fourth clock edge after the write.
- R10: If a single write sets both bit 0 and bit 1, the soft reset has no effect on any state.
- R11: While bit 1 is set, writes to the base (offset 1), configuration (offset 3) and acknowledge registers are ignored, in-service state and irq_o do not change, and reads return the frozen values. Configuration writes place the request number in bits 6:0, the enable in bit 8 and the level in bits 13:12, and reads of offset 3 return that layout for the last number written.
- R12: With control bit 8 set (bypass), irq_o stays low, vector writes and reads mark nothing, and the vector register tracks the winner one edge after the requests change.
- R13: Control bits other than 0, 1, 4 to 6 and 8 to 10 read as zero whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 128 | Interrupt request lines, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register offset: 0 control, 1 base, 2 vector, 3 config, 4 acknowledge |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Interrupt toward the CPU |

## Verification
The spacing arithmetic is swept over every request number with each of the eight spacing codes in bypass mode, using one-hot request patterns. This separates the multiply, the base add and the code decode. Random sparse request patterns over random levels and enables test the winner choice against a priority search in the bench, which exposes mistakes in level order, index tie-break and masking. Directed single-line and multi-line sequences then walk the handshake: same-level, higher-level and nesting-off cases, both in-service marking styles, acknowledge order, gating and the two soft-reset cases.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int DATA_W = 32;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_BASE = 3'd1;
  localparam logic [2:0] RA_VEC  = 3'd2;
  localparam logic [2:0] RA_CFG  = 3'd3;
  localparam logic [2:0] RA_ACK  = 3'd4;

  typedef enum logic {S_WAIT = 1'b0, S_PEND = 1'b1} svc_state_e;

  // spacing in bytes: two low codes share the single-word spacing
  function automatic logic [4:0] spacing_bytes(input logic [2:0] code);
    return (code < 3'd2) ? 5'd4 : {code, 2'b00};
  endfunction

  function automatic logic [DATA_W-1:0] vector_of(input logic [DATA_W-1:0] base,
                                                  input logic [DATA_W-1:0] num,
                                                  input logic [2:0] code);
    return base + num * DATA_W'(spacing_bytes(code));
  endfunction
endpackage

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int N_REQ = 128,
  parameter int LVL_W = 2,
  localparam int IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] pend,
  input  logic [LVL_W-1:0] prio [N_REQ],
  output logic             win_vld,
  output logic [IDX_W-1:0] win_num,
  output logic [LVL_W-1:0] win_lvl
);
  // scan from the top index down; ">=" lets lower indices take ties
  always_comb begin
    win_vld = 1'b0;
    win_num = '0;
    win_lvl = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (pend[i] && (!win_vld || prio[i] >= win_lvl)) begin
        win_vld = 1'b1;
        win_num = IDX_W'(i);
        win_lvl = prio[i];
      end
    end
  end
endmodule

// File: rtl/ivc_ctrlreg.sv
module ivc_ctrlreg
  import ivc_pkg::*;
#(
  parameter int GATE_DLY = 4,
  localparam int CNT_W = $clog2(GATE_DLY) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              srst,
  output logic              gate,
  output logic [2:0]        pitch,
  output logic              bypass,
  output logic              no_nest,
  output logic              rd_mark
);
  logic [CNT_W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst    <= 1'b0;
      gate    <= 1'b0;
      pitch   <= '0;
      bypass  <= 1'b0;
      no_nest <= 1'b0;
      rd_mark <= 1'b0;
      dly_q   <= '0;
    end else begin
      if (wr_en) begin
        srst    <= wdata[0];
        gate    <= wdata[1];
        pitch   <= wdata[6:4];
        bypass  <= wdata[8];
        no_nest <= wdata[9];
        rd_mark <= wdata[10];
      end
      // count edges spent in an effective soft reset, then gate
      if (srst && !gate) begin
        dly_q <= dly_q + 1'b1;
        if (dly_q == CNT_W'(GATE_DLY - 1)) gate <= 1'b1;
      end else begin
        dly_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ivc_service.sv
module ivc_service
  import ivc_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int LVL_W = 2,
  localparam int LVLS = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              bypass,
  input  logic              no_nest,
  input  logic              win_vld,
  input  logic [IDX_W-1:0]  win_num,
  input  logic [LVL_W-1:0]  win_lvl,
  input  logic [DATA_W-1:0] base,
  input  logic [2:0]        pitch,
  input  logic              mark_req,
  input  logic              ack_req,
  input  logic [LVL_W-1:0]  ack_lvl,
  output logic              irq,
  output logic [DATA_W-1:0] vec,
  output logic [LVLS-1:0]   isv,
  output logic              take,
  output logic              mark_fire,
  output logic              ack_fire
);
  svc_state_e       state_q;
  logic [LVL_W-1:0] hold_lvl_q;
  logic [LVLS-1:0]  isv_nx;
  logic             blocked;

  always_comb begin
    blocked = 1'b0;
    for (int l = 0; l < LVLS; l++) begin
      if (isv[l] && l >= int'(win_lvl)) blocked = 1'b1;
    end
  end

  assign take      = run && !bypass && state_q == S_WAIT && win_vld && !blocked
                     && (!no_nest || isv == '0);
  assign mark_fire = run && !bypass && state_q == S_PEND && mark_req;
  assign ack_fire  = run && ack_req;
  assign irq       = state_q == S_PEND && !bypass;

  always_comb begin
    isv_nx = isv;
    if (ack_fire)  isv_nx[ack_lvl]    = 1'b0;
    if (mark_fire) isv_nx[hold_lvl_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_WAIT;
      hold_lvl_q <= '0;
      vec        <= '0;
      isv        <= '0;
    end else if (clr) begin
      state_q    <= S_WAIT;
      hold_lvl_q <= '0;
      vec        <= '0;
      isv        <= '0;
    end else if (run) begin
      isv <= isv_nx;
      if (bypass) begin
        state_q <= S_WAIT;
        vec     <= vector_of(base, DATA_W'(win_num), pitch);
      end else if (take) begin
        state_q    <= S_PEND;
        hold_lvl_q <= win_lvl;
        vec        <= vector_of(base, DATA_W'(win_num), pitch);
      end else if (mark_fire) begin
        state_q <= S_WAIT;
      end
    end
  end
endmodule

// File: rtl/irq_vec_collector.sv
module irq_vec_collector
  import ivc_pkg::*;
#(
  parameter int N_REQ = 128,
  parameter int LVL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REQ-1:0]  irq_req,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam int IDX_W = $clog2(N_REQ);
  localparam int LVLS  = 1 << LVL_W;

  logic srst_w, gate_w, bypass_w, no_nest_w, rd_mark_w, clr_w, run_w;
  logic [2:0] pitch_w;
  logic [DATA_W-1:0] base_q, vec_w;
  logic [N_REQ-1:0]  en_q;
  logic [LVL_W-1:0]  prio_q [N_REQ];
  logic [IDX_W-1:0]  cfg_idx_q, cfg_sel;
  logic              win_vld_w, take_w, mark_fire_w, ack_fire_w, mark_req_w, ack_req_w;
  logic [IDX_W-1:0]  win_num_w;
  logic [LVL_W-1:0]  win_lvl_w, ack_lvl_w;
  logic [LVLS-1:0]   isv_w;

  assign clr_w   = srst_w && !gate_w;
  assign run_w   = !gate_w;
  assign cfg_sel = reg_wdata[IDX_W-1:0];
  assign ack_lvl_w  = reg_wdata[LVL_W-1:0];
  assign ack_req_w  = reg_wr && reg_addr == RA_ACK;
  assign mark_req_w = reg_addr == RA_VEC && (rd_mark_w ? reg_rd : reg_wr);

  ivc_ctrlreg #(.GATE_DLY(4)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && reg_addr == RA_CTRL),
    .wdata(reg_wdata), .srst(srst_w), .gate(gate_w), .pitch(pitch_w),
    .bypass(bypass_w), .no_nest(no_nest_w), .rd_mark(rd_mark_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      en_q      <= '0;
      cfg_idx_q <= '0;
      for (int i = 0; i < N_REQ; i++) prio_q[i] <= '0;
    end else if (clr_w) begin
      base_q    <= '0;
      en_q      <= '0;
      cfg_idx_q <= '0;
      for (int i = 0; i < N_REQ; i++) prio_q[i] <= '0;
    end else if (run_w && reg_wr) begin
      if (reg_addr == RA_BASE) base_q <= reg_wdata;
      if (reg_addr == RA_CFG) begin
        en_q[cfg_sel]   <= reg_wdata[8];
        prio_q[cfg_sel] <= reg_wdata[12 +: LVL_W];
        cfg_idx_q       <= cfg_sel;
      end
    end
  end

  ivc_arbiter #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_arb (
    .pend(irq_req & en_q), .prio(prio_q),
    .win_vld(win_vld_w), .win_num(win_num_w), .win_lvl(win_lvl_w)
  );

  ivc_service #(.IDX_W(IDX_W), .LVL_W(LVL_W)) u_svc (
    .clk(clk), .rst_n(rst_n), .clr(clr_w), .run(run_w), .bypass(bypass_w),
    .no_nest(no_nest_w), .win_vld(win_vld_w), .win_num(win_num_w),
    .win_lvl(win_lvl_w), .base(base_q), .pitch(pitch_w),
    .mark_req(mark_req_w), .ack_req(ack_req_w), .ack_lvl(ack_lvl_w),
    .irq(irq_o), .vec(vec_w), .isv(isv_w), .take(take_w),
    .mark_fire(mark_fire_w), .ack_fire(ack_fire_w)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[0]   = srst_w;
        reg_rdata[1]   = gate_w;
        reg_rdata[6:4] = pitch_w;
        reg_rdata[8]   = bypass_w;
        reg_rdata[9]   = no_nest_w;
        reg_rdata[10]  = rd_mark_w;
      end
      RA_BASE: reg_rdata = base_q;
      RA_VEC:  reg_rdata = vec_w;
      RA_CFG: begin
        reg_rdata[IDX_W-1:0]   = cfg_idx_q;
        reg_rdata[8]           = en_q[cfg_idx_q];
        reg_rdata[12 +: LVL_W] = prio_q[cfg_idx_q];
      end
      RA_ACK:  reg_rdata[LVLS-1:0] = isv_w;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_collector_chk.sv
module irq_vec_collector_chk #(
  parameter int LVL_W = 2,
  localparam int LVLS = 1 << LVL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_rdata,
  input logic             gate_w,
  input logic             clr_w,
  input logic             bypass_w,
  input logic             no_nest_w,
  input logic [LVLS-1:0]  isv_w,
  input logic             win_vld_w,
  input logic [LVL_W-1:0] win_lvl_w,
  input logic             mark_fire_w,
  input logic             ack_fire_w,
  input logic [LVL_W-1:0] ack_lvl_w
);
  assert_mark_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_fire_w |=> !irq_o);

  assert_rise_outranks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(win_vld_w) && (($past(isv_w) >> $past(win_lvl_w)) == '0));

  assert_no_nest_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(!no_nest_w || isv_w == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire_w && !mark_fire_w |=> !isv_w[$past(ack_lvl_w)]);

  assert_gate_after_four_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w && $past(clr_w, 1) && $past(clr_w, 2) && $past(clr_w, 3) |=> gate_w);

  assert_gate_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_w |=> $stable(isv_w) && $stable(irq_o));

  assert_bypass_no_mark_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_w && !ack_fire_w && !clr_w |=> $stable(isv_w));

  assert_ctrl_reserved_R13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd0 |-> (reg_rdata & ~32'h0000_0773) == 32'h0);
endmodule

bind irq_vec_collector irq_vec_collector_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .gate_w(gate_w), .clr_w(clr_w), .bypass_w(bypass_w),
  .no_nest_w(no_nest_w), .isv_w(isv_w), .win_vld_w(win_vld_w),
  .win_lvl_w(win_lvl_w), .mark_fire_w(mark_fire_w), .ack_fire_w(ack_fire_w),
  .ack_lvl_w(ack_lvl_w)
);

// File: tb/irq_vec_collector_bench.sv
`timescale 1ns/1ps
module irq_vec_collector_bench;
  localparam int N = 128;
  localparam logic [31:0] B1 = 32'h0001_0000;
  localparam logic [31:0] B2 = 32'h8000_0400;
  localparam logic [31:0] B3 = 32'h5555_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_o;

  int n_tests = 0, n_fail = 0;
  logic [31:0] seed = 32'h1F2E_3D4C;
  bit b_en [N];
  int b_pr [N];

  always #4 clk = ~clk;

  irq_vec_collector u_irq_vec_collector (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_space(input int code);
    case (code)
      0, 1: return 4;
      2: return 8;
      3: return 12;
      4: return 16;
      5: return 20;
      6: return 24;
      default: return 28;
    endcase
  endfunction

  function automatic int exp_winner(input logic [N-1:0] r);
    for (int lv = 3; lv >= 0; lv--)
      for (int i = 0; i < N; i++)
        if (r[i] && b_en[i] && b_pr[i] == lv) return i;
    return -1;
  endfunction

  function automatic logic [31:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic cfg(input int idx, input bit en, input int pr);
    wr(3'd3, 32'(idx) | (32'(en) << 8) | (32'(pr) << 12));
    b_en[idx] = en; b_pr[idx] = pr;
  endtask

  task automatic set_req(input logic [N-1:0] v);
    @(negedge clk);
    irq_req = v;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] bit_of(input int i);
    return (N'(1)) << i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] r;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    check("R3 irq after reset", 32'(irq_o), 0);
    rd(3'd0, d); check("R3 ctrl reset", d, 0);
    rd(3'd2, d); check("R3 vec reset", d, 0);
    rd(3'd4, d); check("R3 ack reset", d, 0);

    // R13 / R10: reserved bits, soft reset together with gate has no effect
    wr(3'd1, B1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R13 ctrl reserved bits", d, 32'h0000_0773);
    repeat (6) tick();
    wr(3'd0, 32'h0);
    rd(3'd1, d); check("R10 base kept", d, B1);
    rd(3'd0, d); check("R10 ctrl cleared", d, 0);

    // R2 spacing sweep in bypass, one-hot requests
    for (int i = 0; i < N; i++) cfg(i, 1'b1, 0);
    for (int code = 0; code < 8; code++) begin
      wr(3'd1, (code % 2 == 0) ? B1 : B2);
      wr(3'd0, 32'h100 | (32'(code) << 4));
      for (int i = 0; i < N; i++) begin
        set_req(bit_of(i));
        rd(3'd2, d);
        check($sformatf("R2 code %0d req %0d", code, i), d,
              ((code % 2 == 0) ? B1 : B2) + 32'(i * exp_space(code)));
      end
      check("R12 irq low in bypass", 32'(irq_o), 0);
    end

    // R1 random levels, enables and request patterns
    wr(3'd1, B1);
    wr(3'd0, 32'h100);
    for (int i = 0; i < N; i++) begin
      d = next_rand();
      cfg(i, d[3:2] != 2'b00, int'(d[1:0]));
    end
    for (int t = 0; t < 80; t++) begin
      for (int k = 0; k < N / 32; k++) r[k*32 +: 32] = next_rand() & next_rand() & next_rand();
      if (t == 0) r = '0;
      set_req(r);
      rd(3'd2, d);
      w = exp_winner(r);
      check($sformatf("R1 pattern %0d", t), d, (w < 0) ? B1 : B1 + 32'(4 * w));
    end

    // R12 vector write in bypass marks nothing
    set_req(bit_of(5));
    wr(3'd2, 32'h0);
    rd(3'd4, d); check("R12 no mark in bypass", d, 0);

    // R3 R4 R6 R8 normal handshake
    set_req('0);
    wr(3'd0, 32'h0);
    cfg(10, 1'b1, 1); cfg(20, 1'b1, 1); cfg(30, 1'b1, 2);
    set_req(bit_of(10)); tick();
    check("R3 irq raised", 32'(irq_o), 1);
    rd(3'd2, d); check("R3 vector captured", d, B1 + 40);
    check("R4 read without mark keeps irq", 32'(irq_o), 1);
    rd(3'd4, d); check("R4 read marked nothing", d, 0);
    wr(3'd2, 32'h0);
    check("R4 write mark drops irq", 32'(irq_o), 0);
    rd(3'd4, d); check("R4 level1 in service", d, 32'h2);
    set_req(bit_of(10) | bit_of(20)); tick(); tick();
    check("R6 equal level no preempt", 32'(irq_o), 0);
    set_req(bit_of(10) | bit_of(20) | bit_of(30)); tick();
    check("R6 higher level preempts", 32'(irq_o), 1);
    rd(3'd2, d); check("R6 preempt vector", d, B1 + 120);
    wr(3'd2, 32'h0);
    rd(3'd4, d); check("R6 two levels in service", d, 32'h6);
    set_req(bit_of(10) | bit_of(20));
    wr(3'd4, 32'd2);
    rd(3'd4, d); check("R8 ack level2", d, 32'h2);
    check("R8 still blocked by level1", 32'(irq_o), 0);
    wr(3'd4, 32'd1); tick();
    check("R8 ack reopens level1", 32'(irq_o), 1);
    rd(3'd2, d); check("R1 lowest index in level", d, B1 + 40);
    wr(3'd2, 32'h0);
    set_req('0);
    wr(3'd4, 32'd1);
    rd(3'd4, d); check("R8 all clear", d, 0);

    // R7 nesting off
    wr(3'd0, 32'h200);
    set_req(bit_of(10)); tick();
    check("R7 first irq", 32'(irq_o), 1);
    wr(3'd2, 32'h0);
    set_req(bit_of(10) | bit_of(30)); tick(); tick();
    check("R7 no preempt when nesting off", 32'(irq_o), 0);
    wr(3'd4, 32'd1); tick();
    check("R7 irq after ack", 32'(irq_o), 1);
    rd(3'd2, d); check("R7 vector after ack", d, B1 + 120);
    wr(3'd2, 32'h0);
    set_req('0);
    wr(3'd4, 32'd2);
    rd(3'd4, d); check("R7 cleared", d, 0);

    // R5 read marks in service
    wr(3'd0, 32'h400);
    set_req(bit_of(10)); tick();
    check("R5 irq raised", 32'(irq_o), 1);
    rd(3'd2, d); check("R5 vector", d, B1 + 40);
    check("R5 read drops irq", 32'(irq_o), 0);
    rd(3'd4, d); check("R5 level1 in service", d, 32'h2);
    set_req('0);
    wr(3'd4, 32'd1);

    // R11 clock gate freezes state
    wr(3'd0, 32'h0);
    set_req(bit_of(10)); tick();
    wr(3'd2, 32'h0);
    set_req('0);
    wr(3'd0, 32'h2);
    wr(3'd1, B3);
    rd(3'd1, d); check("R11 base write ignored", d, B1);
    wr(3'd4, 32'd1);
    rd(3'd4, d); check("R11 ack ignored", d, 32'h2);
    wr(3'd3, 32'd40 | (32'd3 << 12));
    rd(3'd3, d); check("R11 cfg frozen", d, 32'h0000_211E);
    set_req(bit_of(30)); tick(); tick();
    check("R11 no irq while gated", 32'(irq_o), 0);
    wr(3'd0, 32'h0); tick();
    check("R11 irq after ungate", 32'(irq_o), 1);
    wr(3'd2, 32'h0);
    set_req('0);
    wr(3'd4, 32'd2);

    // R9 soft reset, gate after four edges
    wr(3'd0, 32'h1);
    reg_rd = 1'b1; reg_addr = 3'd0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check($sformatf("R9 gate at edge %0d", k), 32'(reg_rdata[1]), (k == 4) ? 1 : 0);
    end
    reg_rd = 1'b0;
    wr(3'd0, 32'h0);
    rd(3'd1, d); check("R9 base cleared", d, 0);
    rd(3'd3, d); check("R9 cfg cleared", d, 0);
    rd(3'd4, d); check("R9 in service cleared", d, 0);
    rd(3'd2, d); check("R9 vector cleared", d, 0);
    set_req('1); tick(); tick();
    check("R9 enables cleared", 32'(irq_o), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule